// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block counts down from a software-written start value at a rate set by a power-of-two prescaler on the bus clock. A single local vector entry holds three fields: an interrupt vector, a mask and a mode. The mode picks one-shot or periodic operation. Each time the count runs out, an expiry is added to a small pending counter. While the block is enabled and the entry is unmasked, a non-zero pending counter raises an interrupt request that carries the programmed vector.

Configuration comes in as plain register writes: a write strobe, a 2-bit register select and 32 bits of data. The interrupt request leaves on a valid/ready pair. `irq_valid` stays high, with `irq_vector` unchanged, until the consumer takes the request by holding `irq_ready` high on a rising edge. Each accepted transfer removes one pending expiry. When `irq_ready` is low, the only effect is that pending expiries build up, up to a saturating limit. No expiry is ever lost silently while there is room in the counter.

Top module: `irq_countdown_timer`

## Requirements
- R1: A write with select 0 stores the divide configuration. Bits 3, 1 and 0 form a 3-bit code {b3,b1,b0}. That code plus one, wrapped to 3 bits, is the exponent E, and the counter steps once every 2^E clocks. Code 0b111 gives a ratio of 1 and code 0b100 gives a ratio of 32.
- R2: A write with select 1 stores the initial count, drops any countdown in progress, clears the pending counter and restarts the prescaler. From the next cycle, `cur_count` shows the written value.
- R3: An initial count of zero leaves the timer idle. `cur_count` reads 0 and no expiry occurs.
- R4: `cur_count` drops by one on each prescaler step. An initial count N at ratio D expires exactly N*D clocks after the write edge.
- R5: A write with select 2 stores the vector entry: vector in bits 7:0, mask in bit 16, periodic mode in bit 17. In periodic mode, expiry reloads the initial count. In one-shot mode, the count stops at 0 after a single expiry.
- R6: `irq_valid` is high exactly when `sw_en` is high, the mask is clear and the pending counter is non-zero. `irq_vector` carries the entry's vector. A cycle with both `irq_valid` and `irq_ready` high decrements the pending counter by one.
- R7: The pending counter saturates at 2^PEND_W-1 and does not wrap. An expiry that coincides with an accepted transfer at the limit leaves the counter at the limit.
- R8: A falling edge on `sw_en` sets the mask and clears the pending counter. Any vector-entry write made while `sw_en` is low stores the mask as set.
- R9: After reset, the entry has only the mask set (vector 0, one-shot), the divide configuration and initial count are 0, and `cur_count` and `pend_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Global software enable |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 divide, 1 initial count, 2 vector entry |
| cfg_wdata | input | DATA_W | Write data |
| cur_count | output | COUNT_W | Remaining ticks in the current period |
| pend_count | output | PEND_W | Expiries not yet delivered |
| lvt_masked | output | 1 | Current mask bit of the vector entry |
| irq_valid | output | 1 | Interrupt request offered |
| irq_ready | input | 1 | Consumer takes the request |
| irq_vector | output | 8 | Vector of the offered request |

## Verification
The assertions assume that `irq_ready` may be high at any time, whether or not a request is offered. They also assume that `sw_en` is low throughout reset, so a falling enable edge is never seen as the first post-reset event. The stimulus drives every input on the falling clock edge and keeps `sw_en` low until reset is released. It uses only select values 0 to 2. Written counts are kept small enough that each expiry lands at a cycle the bench can predict from N*D.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_LVT  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  localparam int LVT_VEC_LSB  = 0;
  localparam int LVT_MASK_BIT = 16;
  localparam int LVT_PER_BIT  = 17;

  typedef struct packed {
    logic       masked;
    logic       periodic;
    logic [7:0] vector;
  } lvt_t;
endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [3:0] div_cfg,
  output logic       tick
);
  localparam int MAX_EXP = (1 << CODE_W) - 1;
  localparam int PRE_W   = MAX_EXP + 1;

  logic [CODE_W-1:0] exp_code;
  logic [PRE_W-1:0]  limit;
  logic [PRE_W-1:0]  pre_q;
  logic              at_limit;

  always_comb begin
    exp_code = {div_cfg[3], div_cfg[1:0]} + CODE_W'(1);
    limit    = (PRE_W'(1) << exp_code) - PRE_W'(1);
    at_limit = (pre_q >= limit);
  end

  assign tick = at_limit && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (at_limit) pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/tc_countdown.sv
module tc_countdown #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_val,
  input  logic               tick,
  input  logic               periodic,
  output logic [COUNT_W-1:0] count,
  output logic               expire
);
  logic [COUNT_W-1:0] reload_q;
  logic               running_q;
  logic               last_step;

  assign last_step = (count == COUNT_W'(1));
  assign expire    = running_q && tick && last_step && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q  <= '0;
      count     <= '0;
      running_q <= 1'b0;
    end else if (load) begin
      reload_q  <= load_val;
      count     <= load_val;
      running_q <= (load_val != '0);
    end else if (running_q && tick) begin
      if (last_step) begin
        count     <= periodic ? reload_q : '0;
        running_q <= periodic;
      end else begin
        count <= count - COUNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tc_pending.sv
module tc_pending #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              expire,
  input  logic              take,
  output logic [PEND_W-1:0] count
);
  localparam logic [PEND_W-1:0] CNT_MAX = '1;

  logic inc;
  logic dec;

  assign inc = expire && ((count != CNT_MAX) || take);
  assign dec = take && (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (inc && !dec) count <= count + PEND_W'(1);
    else if (dec && !inc) count <= count - PEND_W'(1);
  end
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import tc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32,
  parameter int PEND_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_en,
  input  logic               cfg_wr,
  input  logic [1:0]         cfg_sel,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [COUNT_W-1:0] cur_count,
  output logic [PEND_W-1:0]  pend_count,
  output logic               lvt_masked,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [7:0]         irq_vector
);
  logic [3:0] div_q;
  lvt_t       lvt_q;
  logic       sw_en_q;
  logic       sw_fall;
  logic       wr_div, wr_init, wr_lvt;
  logic       tick, expire, take;

  assign wr_div  = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_DIV);
  assign wr_init = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_INIT);
  assign wr_lvt  = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_LVT);
  assign sw_fall = sw_en_q && !sw_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      sw_en_q <= 1'b0;
      lvt_q   <= '{masked: 1'b1, periodic: 1'b0, vector: 8'h00};
    end else begin
      sw_en_q <= sw_en;
      if (wr_div) div_q <= cfg_wdata[3:0];
      if (wr_lvt) begin
        lvt_q.vector   <= cfg_wdata[LVT_VEC_LSB +: 8];
        lvt_q.periodic <= cfg_wdata[LVT_PER_BIT];
        lvt_q.masked   <= cfg_wdata[LVT_MASK_BIT] || !sw_en;
      end
      if (sw_fall) lvt_q.masked <= 1'b1;
    end
  end

  tc_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_init),
    .div_cfg (div_q),
    .tick    (tick)
  );

  tc_countdown #(.COUNT_W(COUNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_init),
    .load_val (cfg_wdata[COUNT_W-1:0]),
    .tick     (tick),
    .periodic (lvt_q.periodic),
    .count    (cur_count),
    .expire   (expire)
  );

  assign irq_valid  = sw_en && !lvt_q.masked && (pend_count != '0);
  assign irq_vector = lvt_q.vector;
  assign lvt_masked = lvt_q.masked;
  assign take       = irq_valid && irq_ready;

  tc_pending #(.PEND_W(PEND_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (wr_init || sw_fall),
    .expire (expire),
    .take   (take),
    .count  (pend_count)
  );
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32,
  parameter int PEND_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_en,
  input logic               cfg_wr,
  input logic [1:0]         cfg_sel,
  input logic [DATA_W-1:0]  cfg_wdata,
  input logic [COUNT_W-1:0] cur_count,
  input logic [PEND_W-1:0]  pend_count,
  input logic               lvt_masked,
  input logic               irq_valid,
  input logic               irq_ready,
  input logic [7:0]         irq_vector
);
  localparam logic [PEND_W-1:0] P_MAX = '1;

  logic init_wr;
  assign init_wr = cfg_wr && (cfg_sel == 2'd1);

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (pend_count == '0) && (cur_count == $past(cfg_wdata[COUNT_W-1:0])));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_count == '0) && !init_wr) |=> (cur_count == '0));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (sw_en && !lvt_masked && (pend_count != '0)));

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_count == P_MAX) && !(irq_valid && irq_ready) && !init_wr && !$fell(sw_en))
      |=> (pend_count == P_MAX));

  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |=> (lvt_masked && (pend_count == '0)));

  p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lvt_masked && (cur_count == '0) && (pend_count == '0)));
endmodule

bind irq_countdown_timer tc_checker #(
  .DATA_W(DATA_W), .COUNT_W(COUNT_W), .PEND_W(PEND_W)
) u_chk (.*);

// File: tb/irq_countdown_timer_test.sv
module irq_countdown_timer_test;
  localparam int DW = 32;
  localparam int CW = 32;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_en = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = 2'd3;
  logic [DW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cur_count;
  logic [PW-1:0] pend_count;
  logic          lvt_masked;
  logic          irq_valid;
  logic          irq_ready = 1'b0;
  logic [7:0]    irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  irq_countdown_timer #(.DATA_W(DW), .COUNT_W(CW), .PEND_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cur_count(cur_count),
    .pend_count(pend_count), .lvt_masked(lvt_masked), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] data);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take_one(input logic [7:0] vec);
    exp_q.push_back(vec);
    irq_ready = 1'b1;
    @(negedge clk);
    irq_ready = 1'b0;
  endtask

  // monitor: sample well before the rising edge, pop expected vector per transfer
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (irq_valid && irq_ready) begin
        if (exp_q.size() == 0) chk("R6 unexpected transfer", {24'h0, irq_vector}, 32'hFFFF);
        else chk("R6 delivered vector", {24'h0, irq_vector}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      summary();
      $finish;
    end
  end

  initial begin
    edges(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 cur_count", cur_count, 0);
    chk("R9 pend_count", {28'h0, pend_count}, 0);
    chk("R9 masked", {31'h0, lvt_masked}, 1);
    chk("R9 valid", {31'h0, irq_valid}, 0);
    chk("R9 vector", {24'h0, irq_vector}, 0);

    // R1 ratio 1 (code 0b111), R4 one-shot count, R5 one-shot stop
    sw_en = 1'b1;
    wr(2'd0, 32'hB);
    wr(2'd2, 32'h41);
    wr(2'd1, 32'd5);
    chk("R2 loaded count", cur_count, 5);
    edges(4);
    chk("R4 count after 4 ticks", cur_count, 1);
    chk("R4 no early expiry", {28'h0, pend_count}, 0);
    edges(1);
    chk("R1 R4 expiry at N*1", {28'h0, pend_count}, 1);
    chk("R5 one-shot reaches zero", cur_count, 0);
    chk("R6 valid raised", {31'h0, irq_valid}, 1);
    chk("R6 vector", {24'h0, irq_vector}, 32'h41);
    edges(3);
    chk("R5 one-shot no second expiry", {28'h0, pend_count}, 1);
    take_one(8'h41);
    chk("R6 transfer decrements", {28'h0, pend_count}, 0);
    chk("R6 valid drops", {31'h0, irq_valid}, 0);

    // R1 ratio 2 (code 0b000), R5 periodic reload
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h20052);
    wr(2'd1, 32'd3);
    edges(2);
    chk("R1 R4 first tick at edge 2", cur_count, 2);
    edges(3);
    chk("R1 no expiry at edge 5", {28'h0, pend_count}, 0);
    edges(1);
    chk("R4 expiry at N*2", {28'h0, pend_count}, 1);
    chk("R5 periodic reload", cur_count, 3);
    edges(6);
    chk("R5 second period", {28'h0, pend_count}, 2);
    take_one(8'h52);
    take_one(8'h52);
    chk("R6 two transfers drain", {28'h0, pend_count}, 0);

    // R1 ratio 32 (code 0b100)
    wr(2'd0, 32'h8);
    wr(2'd2, 32'h41);
    wr(2'd1, 32'd1);
    edges(31);
    chk("R1 ratio 32 not yet", {28'h0, pend_count}, 0);
    edges(1);
    chk("R1 ratio 32 expiry", {28'h0, pend_count}, 1);
    take_one(8'h41);

    // R7 saturation
    wr(2'd0, 32'hB);
    wr(2'd2, 32'h20041);
    wr(2'd1, 32'd1);
    edges(14);
    chk("R7 counting", {28'h0, pend_count}, 14);
    edges(1);
    chk("R7 at limit", {28'h0, pend_count}, 15);
    edges(5);
    chk("R7 no wrap", {28'h0, pend_count}, 15);
    take_one(8'h41);
    chk("R7 transfer with expiry at limit", {28'h0, pend_count}, 15);

    // R3 zero initial count
    wr(2'd1, 32'd0);
    chk("R3 zero count reads 0", cur_count, 0);
    chk("R2 R3 pending cleared", {28'h0, pend_count}, 0);
    edges(10);
    chk("R3 stays idle", cur_count, 0);
    chk("R3 no expiry", {28'h0, pend_count}, 0);

    // R8 software disable
    wr(2'd2, 32'h41);
    wr(2'd1, 32'd2);
    edges(2);
    chk("R8 setup pending", {28'h0, pend_count}, 1);
    sw_en = 1'b0;
    @(negedge clk);
    chk("R8 pending cleared", {28'h0, pend_count}, 0);
    chk("R8 mask set", {31'h0, lvt_masked}, 1);
    wr(2'd2, 32'h41);
    sw_en = 1'b1;
    @(negedge clk);
    chk("R8 write while disabled stays masked", {31'h0, lvt_masked}, 1);
    wr(2'd2, 32'h41);
    chk("R8 unmask when enabled", {31'h0, lvt_masked}, 0);

    // R6 mask gating
    wr(2'd2, 32'h10063);
    wr(2'd1, 32'd3);
    edges(3);
    chk("R6 masked pending counts", {28'h0, pend_count}, 1);
    chk("R6 masked no valid", {31'h0, irq_valid}, 0);
    wr(2'd2, 32'h63);
    chk("R6 unmasked valid", {31'h0, irq_valid}, 1);
    chk("R6 unmasked vector", {24'h0, irq_vector}, 32'h63);
    take_one(8'h63);

    // R2 restart mid-run
    wr(2'd2, 32'h20041);
    wr(2'd1, 32'd2);
    edges(4);
    chk("R2 setup pending", {28'h0, pend_count}, 2);
    wr(2'd1, 32'd6);
    chk("R2 restart clears pending", {28'h0, pend_count}, 0);
    chk("R2 restart count", cur_count, 6);
    edges(3);
    chk("R2 R4 counts from new value", cur_count, 3);
    wr(2'd1, 32'd0);

    edges(2);
    chk("R6 scoreboard empty", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule